// File: doc/BRIEF.md
# Global Output-Disable Controller

This block produces one chip-wide disable level and the pad-control strobes that follow from it. When the disable is active, every user output driver is switched to high impedance. User inputs get a pull-up with the pull-down released. The test-data output is floated. The done pin driver is floated and its input gets a pull-up. The I/O buffers and the threshold circuitry themselves are outside this block; it only drives their control lines.

The source of the disable changes when configuration completes. While the configuration-complete flag is low, the disable follows a dedicated control pad and is active low. Once the flag is high, a two-bit source select and a polarity option take over. The select can turn the function off, route the control pad, or route a general routing signal from the fabric. The polarity option can flip the active sense to active high. All outputs are registered, so each one reflects the inputs sampled on the previous rising clock edge.

Top module: `gts_ctrl`

## Requirements
- R1: While `rst_n` is low, after any rising edge of `clk`, every output is 1. This means disable active and all pad strobes asserted.
- R2: While `cfg_done_i` is 0, `gdis_o` equals the inverse of `ctl_pad_i`, so a low pad means disabled. `src_sel_i`, `invert_i` and `route_i` have no effect.
- R3: With `cfg_done_i` at 1 and `src_sel_i` = 2'b00 (off), `gdis_o` is 0 whatever the pad and routing inputs are.
- R4: With `cfg_done_i` at 1 and `src_sel_i` = 2'b01 (pad), `gdis_o` follows the control pad. It is the inverse of `ctl_pad_i` when `invert_i` is 0, and equals `ctl_pad_i` when `invert_i` is 1.
- R5: With `cfg_done_i` at 1 and `src_sel_i` = 2'b10 (routing), `gdis_o` follows the routing signal. It is the inverse of `route_i` when `invert_i` is 0, and equals `route_i` when `invert_i` is 1.
- R6: With `cfg_done_i` at 1 and `src_sel_i` = 2'b11 (reserved), `gdis_o` is 0, the same as off.
- R7: `user_oe_kill_o`, `in_pullup_en_o` and `in_pulldown_dis_o` always equal `gdis_o` in the same cycle.
- R8: `tdo_hiz_o`, `done_hiz_o` and `done_pullup_o` always equal `gdis_o` in the same cycle.
- R9: Outputs change only on a rising clock edge, one cycle after the inputs are sampled. An input change between edges leaves the outputs as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done_i | input | 1 | Configuration-complete flag |
| ctl_pad_i | input | 1 | Dedicated control pad input |
| route_i | input | 1 | General routing signal from the fabric |
| src_sel_i | input | 2 | Post-configuration source: 00 off, 01 pad, 10 routing, 11 reserved (off) |
| invert_i | input | 1 | Post-configuration polarity: 1 makes the source active high |
| gdis_o | output | 1 | Global disable level, 1 = disabled |
| user_oe_kill_o | output | 1 | Forces all user output drivers to high impedance |
| in_pullup_en_o | output | 1 | Enables the pull-up on user inputs |
| in_pulldown_dis_o | output | 1 | Turns off the pull-down on user inputs |
| tdo_hiz_o | output | 1 | Floats the test-data output |
| done_hiz_o | output | 1 | Floats the done pin driver |
| done_pullup_o | output | 1 | Enables the pull-up on the done pin input |

## Verification
Before configuration completes, the bench applies select and polarity values that would produce a different result after completion. A design that honoured them too early would follow the routing signal or flip polarity, and the check would report it.

The reserved select code 11 is driven with inputs that would assert the disable if that code were decoded as pad or routing. The inverted polarity is tested on both sources, so a swapped polarity or a swapped source shows up as a mismatched level.

The bench also samples just after an input change and before the next edge. This catches a combinational path that bypasses the output register. A reset applied in the middle of a run must bring every strobe back to the disabled state.

// File: rtl/gts_pkg.sv
package gts_pkg;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'b00,
        SRC_PAD   = 2'b01,
        SRC_ROUTE = 2'b10,
        SRC_RSVD  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic oe_kill;
        logic pu_en;
        logic pd_dis;
        logic tdo_hiz;
        logic done_hiz;
        logic done_pu;
    } pad_ctl_t;

    localparam int PAD_CTL_W = $bits(pad_ctl_t);

    typedef struct packed {
        logic     gdis;
        pad_ctl_t pads;
    } gts_state_t;

endpackage

// File: rtl/gts_src_mux.sv
module gts_src_mux
    import gts_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             cfg_done,
    input  logic             pad,
    input  logic             route,
    input  logic [SEL_W-1:0] sel,
    input  logic             inv,
    output logic             active
);
    src_sel_e sel_e;
    logic     raw;
    logic     enabled;

    always_comb begin
        sel_e   = src_sel_e'(sel[1:0]);
        raw     = 1'b1;
        enabled = 1'b0;
        unique case (sel_e)
            SRC_PAD: begin
                raw     = pad;
                enabled = 1'b1;
            end
            SRC_ROUTE: begin
                raw     = route;
                enabled = 1'b1;
            end
            default: begin
                raw     = 1'b1;
                enabled = 1'b0;
            end
        endcase

        if (!cfg_done) begin
            // configuration phase: pad only, active low
            active = ~pad;
        end else if (!enabled) begin
            active = 1'b0;
        end else begin
            active = inv ? raw : ~raw;
        end
    end

endmodule

// File: rtl/gts_pad_ctrl.sv
module gts_pad_ctrl
    import gts_pkg::*;
(
    input  logic     active,
    output pad_ctl_t pads
);
    always_comb begin
        pads          = '0;
        pads.oe_kill  = active;
        pads.pu_en    = active;
        pads.pd_dis   = active;
        pads.tdo_hiz  = active;
        pads.done_hiz = active;
        pads.done_pu  = active;
    end

endmodule

// File: rtl/gts_ctrl.sv
module gts_ctrl
    import gts_pkg::*;
#(
    parameter int   SEL_W          = 2,
    parameter logic RESET_DISABLED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done_i,
    input  logic             ctl_pad_i,
    input  logic             route_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic             invert_i,
    output logic             gdis_o,
    output logic             user_oe_kill_o,
    output logic             in_pullup_en_o,
    output logic             in_pulldown_dis_o,
    output logic             tdo_hiz_o,
    output logic             done_hiz_o,
    output logic             done_pullup_o
);
    localparam int         ST_W     = 1 + PAD_CTL_W;
    localparam gts_state_t ST_RESET = gts_state_t'({ST_W{RESET_DISABLED}});

    logic       active;
    pad_ctl_t   pads_next;
    gts_state_t st_d;
    gts_state_t st_q;

    gts_src_mux #(.SEL_W(SEL_W)) u_mux (
        .cfg_done (cfg_done_i),
        .pad      (ctl_pad_i),
        .route    (route_i),
        .sel      (src_sel_i),
        .inv      (invert_i),
        .active   (active)
    );

    gts_pad_ctrl u_pads (
        .active (active),
        .pads   (pads_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gdis = active;
        st_d.pads = pads_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign gdis_o            = st_q.gdis;
    assign user_oe_kill_o    = st_q.pads.oe_kill;
    assign in_pullup_en_o    = st_q.pads.pu_en;
    assign in_pulldown_dis_o = st_q.pads.pd_dis;
    assign tdo_hiz_o         = st_q.pads.tdo_hiz;
    assign done_hiz_o        = st_q.pads.done_hiz;
    assign done_pullup_o     = st_q.pads.done_pu;

endmodule

// File: rtl/gts_ctrl_chk.sv
module gts_ctrl_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_done_i,
    input logic             ctl_pad_i,
    input logic             route_i,
    input logic [SEL_W-1:0] src_sel_i,
    input logic             invert_i,
    input logic             gdis_o,
    input logic             user_oe_kill_o,
    input logic             in_pullup_en_o,
    input logic             in_pulldown_dis_o,
    input logic             tdo_hiz_o,
    input logic             done_hiz_o,
    input logic             done_pullup_o
);
    logic past_ok;
    logic rst_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1: reset drives the disabled state
    always @(negedge clk) begin
        if (!rst_n && rst_seen) begin
            a_r1_reset_disabled: assert (gdis_o && user_oe_kill_o && done_hiz_o);
        end
    end

    a_r2_preconfig_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cfg_done_i)) |-> (gdis_o == !$past(ctl_pad_i)));

    a_r3_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_done_i) && $past(src_sel_i) == 2'b00) |-> !gdis_o);

    a_r4_sel_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_done_i) && $past(src_sel_i) == 2'b01)
        |-> (gdis_o == ($past(invert_i) ? $past(ctl_pad_i) : !$past(ctl_pad_i))));

    a_r5_sel_route: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_done_i) && $past(src_sel_i) == 2'b10)
        |-> (gdis_o == ($past(invert_i) ? $past(route_i) : !$past(route_i))));

    a_r6_sel_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_done_i) && $past(src_sel_i) == 2'b11) |-> !gdis_o);

    a_r7_user_pads: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (user_oe_kill_o == gdis_o && in_pullup_en_o == gdis_o
                     && in_pulldown_dis_o == gdis_o));

    a_r8_cfg_pads: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (tdo_hiz_o == gdis_o && done_hiz_o == gdis_o
                     && done_pullup_o == gdis_o));

endmodule

bind gts_ctrl gts_ctrl_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_gts_ctrl.sv
module sim_gts_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       cfg_done = 1'b0;
    logic       pad = 1'b1;
    logic       route = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       inv = 1'b0;
    logic gdis, oe_kill, pu_en, pd_dis, tdo_hiz, done_hiz, done_pu;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    gts_ctrl u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_done_i        (cfg_done),
        .ctl_pad_i         (pad),
        .route_i           (route),
        .src_sel_i         (sel),
        .invert_i          (inv),
        .gdis_o            (gdis),
        .user_oe_kill_o    (oe_kill),
        .in_pullup_en_o    (pu_en),
        .in_pulldown_dis_o (pd_dis),
        .tdo_hiz_o         (tdo_hiz),
        .done_hiz_o        (done_hiz),
        .done_pullup_o     (done_pu)
    );

    // {cfg_done, pad, route, sel[1:0], inv, expected disable}
    localparam int NV = 17;
    localparam logic [6:0] VECS [0:NV-1] = '{
        7'b0000001, 7'b0100000, 7'b0011011, 7'b0111010, 7'b0100110,
        7'b1010000, 7'b1010010,
        7'b1010101, 7'b1100100, 7'b1100111, 7'b1010110,
        7'b1101001, 7'b1111000, 7'b1011011, 7'b1001010,
        7'b1001100, 7'b1011110
    };

    function automatic string req_of(logic c, logic [1:0] s);
        if (!c)          return "R2";
        if (s == 2'b00)  return "R3";
        if (s == 2'b01)  return "R4";
        if (s == 2'b10)  return "R5";
        return "R6";
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_all(string req, logic exp);
        check(req, gdis, exp);
        check("R7", oe_kill, exp);
        check("R7", pu_en, exp);
        check("R7", pd_dis, exp);
        check("R8", tdo_hiz, exp);
        check("R8", done_hiz, exp);
        check("R8", done_pu, exp);
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state is fully disabled, even with inputs saying enable
        #1 rst_n = 1'b0;
        cfg_done = 1'b1;
        sel      = 2'b00;
        @(posedge clk);
        @(negedge clk);
        check_all("R1", 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R3", 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cfg_done, pad, route, sel, inv} = VECS[i][6:1];
            @(negedge clk);
            check_all(req_of(VECS[i][6], VECS[i][3:2]), VECS[i][0]);
        end

        // R9: output holds between edges, then updates after one edge
        @(negedge clk);
        cfg_done = 1'b1; sel = 2'b01; inv = 1'b0; pad = 1'b1;
        @(negedge clk);
        check("R9", gdis, 1'b0);
        pad = 1'b0;
        #1;
        check("R9", gdis, 1'b0);
        @(posedge clk);
        #1;
        check("R9", gdis, 1'b1);

        // R2: fresh reconfiguration phase ignores an inverting routing source
        @(negedge clk);
        cfg_done = 1'b0; sel = 2'b10; inv = 1'b1; route = 1'b1; pad = 1'b1;
        @(negedge clk);
        check_all("R2", 1'b0);

        // R1: mid-run reset forces the disabled state again
        @(negedge clk);
        cfg_done = 1'b1; sel = 2'b00;
        @(negedge clk);
        check("R3", gdis, 1'b0);
        rst_n = 1'b0;
        #1;
        check_all("R1", 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R3", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule